// File: doc/BRIEF.md
# Five-Pin Shared-Function Port Controller

This block owns a five-pin bidirectional port in which every pin may be lent to a neighbouring peripheral. The two upper pins are shared with the differential data lines of a USB transceiver. When USB is off, they become open-drain lines that can only pull low, suited to a PS/2 clock and data pair. The two middle pins are shared with a pair of timer capture/compare channels. The lowest pin can become the timer's external clock input. The block holds the output latch and the direction register behind a small register bus. It decides which party drives each pad and builds the port read value. It also drives the two pull-up controls of the top pin and raises a latched interrupt request on a falling edge of that pin.

Ownership is decided by signals from other modules: the USB enable, the D- pull-up request, the timer edge/level selects of each channel and the timer prescaler code. When a peripheral owns a pin, it controls that pin's output enable and value. Reads of the port still follow the direction bit: a 1 returns the latch and a 0 returns the synchronized pad level.

Top module: `mux_port_ctrl`

## Requirements
- R1: After reset the latch, direction and control registers are zero, every pad output enable is low and the interrupt request is low.
- R2: With `usb_en` high, pads 4 and 3 take output enable and value from `usb_dm_oe`/`usb_dm_out` and `usb_dp_oe`/`usb_dp_out`, and `usb_dm_in`/`usb_dp_in` mirror the raw pads.
- R3: With `usb_en` low, pads 4 and 3 are open-drain: the pad value is 0 and the enable is set only when the direction bit is 1 and the latch bit is 0.
- R4: A falling edge of the synchronized pad 4 sets a sticky pending flag, seen on `irq_req`, only while control bit 0 (interrupt enable) is 1 and `usb_en` is 0.
- R5: Writing a 1 to bit 0 at address 3 clears the pending flag. Reading address 3 returns the flag in bit 0.
- R6: `pu4_port_en` equals control bit 1 while USB is off and is 0 otherwise. `pu4_dm_en` equals `usb_pullup_req` while USB is on and is 0 otherwise.
- R7: Pad 2 (channel 1, selects `tim_els[3:2]`) and pad 1 (channel 0, selects `tim_els[1:0]`) take enable and value from the timer when their select pair is non-zero, whatever the direction bit. `tim_ch_in` always carries the synchronized pads.
- R8: When a channel's select pair is zero, and for pads 2..0 when not owned, the enable is the direction bit and the value is the latch bit.
- R9: A prescaler code of 3'b111 makes pad 0 an input (enable 0) and sends its synchronized level to `tim_clk_in`. Any other code leaves pad 0 as GPIO and holds `tim_clk_in` low.
- R10: Reading address 0 returns, per bit, the latch where the direction bit is 1 and the synchronized pad where it is 0. This holds for owned pins too. Bits 7..5 read 0.
- R11: Pad levels reach the read path, the interrupt logic and the timer inputs through a two-stage synchronizer. Address 1 reads the direction register and address 2 reads the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 direction, 2 control, 3 pending/ack |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| usb_en | input | 1 | USB owns pads 4 and 3 |
| usb_pullup_req | input | 1 | Request for the D- pull-up |
| usb_dm_oe | input | 1 | USB D- drive enable |
| usb_dm_out | input | 1 | USB D- drive value |
| usb_dp_oe | input | 1 | USB D+ drive enable |
| usb_dp_out | input | 1 | USB D+ drive value |
| usb_dm_in | output | 1 | Raw pad 4 to the transceiver |
| usb_dp_in | output | 1 | Raw pad 3 to the transceiver |
| tim_els | input | 4 | Edge/level selects, channel 1 in [3:2], channel 0 in [1:0] |
| tim_ch_oe | input | 2 | Timer channel drive enables |
| tim_ch_out | input | 2 | Timer channel drive values |
| tim_ch_in | output | 2 | Synchronized pads 2 and 1 |
| tim_ps | input | 3 | Timer prescaler select |
| tim_clk_in | output | 1 | External timer clock from pad 0 |
| pad_in | input | 5 | Pad levels |
| pad_oe | output | 5 | Pad output enables |
| pad_out | output | 5 | Pad output values |
| pu4_port_en | output | 1 | Port pull-up on pad 4 |
| pu4_dm_en | output | 1 | D- pull-up on pad 4 |
| irq_req | output | 1 | Pending external interrupt |

## Verification
The assertions assume the ownership inputs (`usb_en`, `tim_els`, `tim_ps`) come from registers and so change only between clock edges. They also assume an interrupt acknowledge is the only way the pending flag falls. The bench drives every input on the falling clock edge and holds pad levels for at least three cycles before it samples, so the synchronizer delay stays inside each step. It sweeps all direction/latch pairs, all channel select codes and all prescaler codes.

// File: rtl/mgp_pkg.sv
package mgp_pkg;
   localparam int NPIN    = 5;
   localparam int DW      = 8;
   localparam int AW      = 2;
   localparam int PIN_DM  = 4;
   localparam int PIN_DP  = 3;
   localparam int PIN_CH1 = 2;
   localparam int PIN_CH0 = 1;
   localparam int PIN_CLK = 0;
   localparam int NCH     = 2;

   typedef enum logic [AW-1:0] {
      REG_DATA = 2'd0,
      REG_DIR  = 2'd1,
      REG_CTRL = 2'd2,
      REG_PEND = 2'd3
   } reg_sel_e;

   localparam int CTRL_IRQ_EN = 0;
   localparam int CTRL_PU_EN  = 1;
   localparam int CTRL_W      = 2;
endpackage

// File: rtl/mgp_sync.sv
module mgp_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("mgp_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mgp_regs.sv
module mgp_regs
   import mgp_pkg::*;
#(
   parameter int N = NPIN
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [N-1:0]  port_rd,
   input  logic          pend,
   output logic [N-1:0]  latch,
   output logic [N-1:0]  ddr,
   output logic          irq_en,
   output logic          pu_en,
   output logic          ack,
   output logic [DW-1:0] rdata
);
   generate
      if (N > DW) begin : g_bad
         $error("mgp_regs: pin count exceeds data width");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch <= '0;
         ddr   <= '0;
         ctrl  <= '0;
      end else if (we) begin
         case (reg_sel_e'(addr))
            REG_DATA: latch <= wdata[N-1:0];
            REG_DIR:  ddr   <= wdata[N-1:0];
            REG_CTRL: ctrl  <= wdata[CTRL_W-1:0];
            default:  ;
         endcase
      end
   end

   assign irq_en = ctrl[CTRL_IRQ_EN];
   assign pu_en  = ctrl[CTRL_PU_EN];
   assign ack    = we && (reg_sel_e'(addr) == REG_PEND) && wdata[0];

   always_comb begin
      rdata = '0;
      case (reg_sel_e'(addr))
         REG_DATA: rdata[N-1:0]      = port_rd;
         REG_DIR:  rdata[N-1:0]      = ddr;
         REG_CTRL: rdata[CTRL_W-1:0] = ctrl;
         REG_PEND: rdata[0]          = pend;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/mgp_pin_mux.sv
module mgp_pin_mux
   import mgp_pkg::*;
#(
   parameter logic [2:0] EXT_CLK_CODE = 3'b111
) (
   input  logic              usb_en,
   input  logic              usb_dm_oe,
   input  logic              usb_dm_out,
   input  logic              usb_dp_oe,
   input  logic              usb_dp_out,
   input  logic [2*NCH-1:0]  tim_els,
   input  logic [NCH-1:0]    tim_ch_oe,
   input  logic [NCH-1:0]    tim_ch_out,
   input  logic [2:0]        tim_ps,
   input  logic [NPIN-1:0]   latch,
   input  logic [NPIN-1:0]   ddr,
   input  logic [NPIN-1:0]   pin_s,
   output logic [NPIN-1:0]   pad_oe,
   output logic [NPIN-1:0]   pad_out,
   output logic [NPIN-1:0]   port_rd,
   output logic              clk_sel
);
   logic [1:0] od_pin;
   logic [1:0] usb_oe;
   logic [1:0] usb_out;

   assign usb_oe  = {usb_dm_oe,  usb_dp_oe};
   assign usb_out = {usb_dm_out, usb_dp_out};

   // shared USB / open-drain pins (index 1 -> pad 4, index 0 -> pad 3)
   generate
      for (genvar k = 0; k < 2; k++) begin : g_usb
         localparam int P = PIN_DP + k;
         assign od_pin[k]  = ddr[P] & ~latch[P];
         assign pad_oe[P]  = usb_en ? usb_oe[k]  : od_pin[k];
         assign pad_out[P] = usb_en ? usb_out[k] : 1'b0;
      end
   endgenerate

   // timer channel pins
   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         localparam int P = PIN_CH0 + c;
         logic owned;
         assign owned      = |tim_els[2*c +: 2];
         assign pad_oe[P]  = owned ? tim_ch_oe[c]  : ddr[P];
         assign pad_out[P] = owned ? tim_ch_out[c] : latch[P];
      end
   endgenerate

   // external timer clock pin
   assign clk_sel           = (tim_ps == EXT_CLK_CODE);
   assign pad_oe[PIN_CLK]   = clk_sel ? 1'b0 : ddr[PIN_CLK];
   assign pad_out[PIN_CLK]  = latch[PIN_CLK];

   // read path ignores ownership
   generate
      for (genvar i = 0; i < NPIN; i++) begin : g_rd
         assign port_rd[i] = ddr[i] ? latch[i] : pin_s[i];
      end
   endgenerate
endmodule

// File: rtl/mgp_ext_irq.sv
module mgp_ext_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic arm,
   input  logic ack,
   output logic pend
);
   logic prev;
   logic fall;

   assign fall = prev & ~pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b0;
         pend <= 1'b0;
      end else begin
         prev <= pin_s;
         if (arm && fall) pend <= 1'b1;
         else if (ack)    pend <= 1'b0;
      end
   end
endmodule

// File: rtl/mux_port_ctrl.sv
module mux_port_ctrl
   import mgp_pkg::*;
#(
   parameter int         SYNC_STAGES  = 2,
   parameter logic [2:0] EXT_CLK_CODE = 3'b111
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [1:0]    bus_addr,
   input  logic [7:0]    bus_wdata,
   output logic [7:0]    bus_rdata,
   input  logic          usb_en,
   input  logic          usb_pullup_req,
   input  logic          usb_dm_oe,
   input  logic          usb_dm_out,
   input  logic          usb_dp_oe,
   input  logic          usb_dp_out,
   output logic          usb_dm_in,
   output logic          usb_dp_in,
   input  logic [3:0]    tim_els,
   input  logic [1:0]    tim_ch_oe,
   input  logic [1:0]    tim_ch_out,
   output logic [1:0]    tim_ch_in,
   input  logic [2:0]    tim_ps,
   output logic          tim_clk_in,
   input  logic [4:0]    pad_in,
   output logic [4:0]    pad_oe,
   output logic [4:0]    pad_out,
   output logic          pu4_port_en,
   output logic          pu4_dm_en,
   output logic          irq_req
);
   logic [NPIN-1:0] pin_s;
   logic [NPIN-1:0] latch;
   logic [NPIN-1:0] ddr;
   logic [NPIN-1:0] port_rd;
   logic            irq_en;
   logic            pu_en;
   logic            ack;
   logic            pend;
   logic            clk_sel;

   mgp_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s)
   );

   mgp_regs #(.N(NPIN)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .port_rd(port_rd), .pend(pend),
      .latch(latch), .ddr(ddr), .irq_en(irq_en), .pu_en(pu_en),
      .ack(ack), .rdata(bus_rdata)
   );

   mgp_pin_mux #(.EXT_CLK_CODE(EXT_CLK_CODE)) u_mux (
      .usb_en(usb_en), .usb_dm_oe(usb_dm_oe), .usb_dm_out(usb_dm_out),
      .usb_dp_oe(usb_dp_oe), .usb_dp_out(usb_dp_out),
      .tim_els(tim_els), .tim_ch_oe(tim_ch_oe), .tim_ch_out(tim_ch_out),
      .tim_ps(tim_ps), .latch(latch), .ddr(ddr), .pin_s(pin_s),
      .pad_oe(pad_oe), .pad_out(pad_out), .port_rd(port_rd),
      .clk_sel(clk_sel)
   );

   mgp_ext_irq u_irq (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s[PIN_DM]),
      .arm(irq_en & ~usb_en), .ack(ack), .pend(pend)
   );

   assign irq_req     = pend;
   assign usb_dm_in   = pad_in[PIN_DM];
   assign usb_dp_in   = pad_in[PIN_DP];
   assign tim_ch_in   = pin_s[PIN_CH1:PIN_CH0];
   assign tim_clk_in  = clk_sel & pin_s[PIN_CLK];
   assign pu4_port_en = pu_en & ~usb_en;
   assign pu4_dm_en   = usb_pullup_req & usb_en;
endmodule

// File: rtl/mux_port_ctrl_chk.sv
module mux_port_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_we,
   input logic [1:0] bus_addr,
   input logic [7:0] bus_wdata,
   input logic       usb_en,
   input logic       usb_dm_oe,
   input logic [3:0] tim_els,
   input logic [1:0] tim_ch_oe,
   input logic [2:0] tim_ps,
   input logic [4:0] pad_oe,
   input logic [4:0] pad_out,
   input logic       pu4_port_en,
   input logic       pu4_dm_en,
   input logic       irq_req
);
   assert_usb_dm_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      usb_en |-> pad_oe[4] == usb_dm_oe);

   assert_open_drain_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !usb_en |-> pad_out[4:3] == 2'b00);

   assert_irq_needs_usb_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> $past(!usb_en));

   assert_irq_clear_by_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_req) |-> $past(bus_we && bus_addr == 2'd3 && bus_wdata[0]));

   assert_pullups_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(pu4_port_en && pu4_dm_en));

   assert_timer_owns_ch1_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tim_els[3:2] != 2'b00) |-> pad_oe[2] == tim_ch_oe[1]);

   assert_clk_pin_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tim_ps == 3'b111) |-> !pad_oe[0]);
endmodule

bind mux_port_ctrl mux_port_ctrl_chk u_chk (.*);

// File: tb/mux_port_ctrl_test.sv
module mux_port_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       usb_en = 1'b0, usb_pullup_req = 1'b0;
   logic       usb_dm_oe = 1'b0, usb_dm_out = 1'b0, usb_dp_oe = 1'b0, usb_dp_out = 1'b0;
   logic       usb_dm_in, usb_dp_in;
   logic [3:0] tim_els = '0;
   logic [1:0] tim_ch_oe = '0, tim_ch_out = '0, tim_ch_in;
   logic [2:0] tim_ps = '0;
   logic       tim_clk_in;
   logic [4:0] pad_in = '0, pad_oe, pad_out;
   logic       pu4_port_en, pu4_dm_en, irq_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mux_port_ctrl uut (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
      bus_addr = a;
      #1;
      chk(bus_rdata == exp, tag, bus_rdata, exp);
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [4:0] eoe, eout, erd, p;
      settle(2);
      // R1 reset state
      chk(pad_oe == 5'b0, "R1 oe", pad_oe, 0);
      chk(irq_req == 1'b0, "R1 irq", irq_req, 0);
      rst_n = 1'b1;
      settle(1);
      rd_chk(2'd1, 8'h00, "R1 dir");
      rd_chk(2'd2, 8'h00, "R1 ctrl");
      rd_chk(2'd0, 8'h00, "R1 data");

      // R3 R8 R10 R11: full direction x latch sweep, USB off, no timer ownership
      for (int d = 0; d < 32; d++) begin
         for (int l = 0; l < 32; l++) begin
            p = 5'((d * 7 + l * 3) & 31);
            pad_in = p;
            wr(2'd1, 8'(d));
            wr(2'd0, 8'(l));
            settle(2);
            eoe  = {d[4] & ~l[4], d[3] & ~l[3], d[2:0]};
            eout = {2'b00, l[2:0]};
            erd  = (5'(d) & 5'(l)) | (~5'(d) & p);
            chk(pad_oe == eoe, "R3_R8 oe", pad_oe, eoe);
            chk(pad_out == eout, "R3_R8 out", pad_out, eout);
            rd_chk(2'd0, {3'b000, erd}, "R10 read");
         end
      end
      rd_chk(2'd1, 8'h1f, "R11 dir readback");

      // R2 USB ownership of pads 4 and 3
      usb_en = 1'b1;
      for (int u = 0; u < 16; u++) begin
         {usb_dm_oe, usb_dm_out, usb_dp_oe, usb_dp_out} = 4'(u);
         pad_in = {u[0], u[1], 3'b000};
         #1;
         chk(pad_oe[4:3] == {u[3], u[1]}, "R2 oe", pad_oe[4:3], {u[3], u[1]});
         chk(pad_out[4:3] == {u[2], u[0]}, "R2 out", pad_out[4:3], {u[2], u[0]});
         chk({usb_dm_in, usb_dp_in} == {u[0], u[1]}, "R2 in", {usb_dm_in, usb_dp_in}, {u[0], u[1]});
         @(negedge clk);
      end

      // R6 pull-ups
      for (int c = 0; c < 8; c++) begin
         usb_en = c[0]; usb_pullup_req = c[1];
         wr(2'd2, {6'b0, c[2], 1'b0});
         rd_chk(2'd2, {6'b0, c[2], 1'b0}, "R11 ctrl readback");
         chk(pu4_port_en == (c[2] & ~c[0]), "R6 port pu", pu4_port_en, c[2] & ~c[0]);
         chk(pu4_dm_en == (c[1] & c[0]), "R6 dm pu", pu4_dm_en, c[1] & c[0]);
      end
      usb_en = 1'b0; usb_pullup_req = 1'b0;

      // R7 R8 timer channels: direction cleared, latch cleared
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h00);
      pad_in = 5'b00100;
      settle(3);
      for (int e = 0; e < 16; e++) begin
         for (int t = 0; t < 16; t++) begin
            logic [1:0] own, xoe, xout;
            tim_els = 4'(e);
            {tim_ch_oe, tim_ch_out} = 4'(t);
            own  = {|e[3:2], |e[1:0]};
            xoe  = own & tim_ch_oe;
            xout = own & tim_ch_out;
            #1;
            chk(pad_oe[2:1] == xoe, "R7_R8 oe", pad_oe[2:1], xoe);
            chk(pad_out[2:1] == xout, "R7_R8 out", pad_out[2:1], xout);
            @(negedge clk);
         end
      end
      chk(tim_ch_in == 2'b10, "R7 ch in", tim_ch_in, 2'b10);
      // R10 read follows direction on owned pins
      tim_els = 4'hf;
      wr(2'd1, 8'h04);
      wr(2'd0, 8'h02);
      pad_in = 5'b00010;
      settle(3);
      rd_chk(2'd0, 8'h02, "R10 owned read");
      chk(pad_oe[2:1] == tim_ch_oe, "R7 ddr ignored", pad_oe[2:1], tim_ch_oe);
      tim_els = 4'h0;

      // R9 prescaler sweep
      wr(2'd1, 8'h01);
      wr(2'd0, 8'h01);
      pad_in = 5'b00001;
      settle(3);
      for (int s = 0; s < 8; s++) begin
         tim_ps = 3'(s);
         #1;
         chk(pad_oe[0] == (s != 7), "R9 oe", pad_oe[0], s != 7);
         chk(tim_clk_in == (s == 7), "R9 clk", tim_clk_in, s == 7);
         @(negedge clk);
      end
      tim_ps = 3'd0;

      // R11 synchronizer latency: change visible after two edges
      wr(2'd1, 8'h00);
      pad_in = 5'b00000;
      settle(3);
      pad_in = 5'b00001;
      bus_addr = 2'd0;
      @(negedge clk);
      chk(bus_rdata[0] == 1'b0, "R11 sync one edge", bus_rdata[0], 0);
      @(negedge clk);
      chk(bus_rdata[0] == 1'b1, "R11 sync two edges", bus_rdata[0], 1);

      // R4 R5 external interrupt
      wr(2'd2, 8'h01);
      pad_in = 5'b10000; settle(4);
      pad_in = 5'b00000; settle(4);
      chk(irq_req == 1'b1, "R4 fall sets", irq_req, 1);
      rd_chk(2'd3, 8'h01, "R5 pend read");
      pad_in = 5'b10000; settle(4);
      chk(irq_req == 1'b1, "R4 sticky", irq_req, 1);
      wr(2'd3, 8'h00);
      chk(irq_req == 1'b1, "R5 ack zero ignored", irq_req, 1);
      wr(2'd3, 8'h01);
      chk(irq_req == 1'b0, "R5 ack clears", irq_req, 0);
      usb_en = 1'b1;
      pad_in = 5'b00000; settle(4);
      chk(irq_req == 1'b0, "R4 usb blocks", irq_req, 0);
      pad_in = 5'b10000; settle(4);
      usb_en = 1'b0;
      wr(2'd2, 8'h00);
      pad_in = 5'b00000; settle(4);
      chk(irq_req == 1'b0, "R4 enable off blocks", irq_req, 0);
      rd_chk(2'd3, 8'h00, "R5 pend clear read");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule